// File: doc/BRIEF.md
# ECC Error Log and Status Register

This block records memory error events coming from the single-error-correct, double-error-detect checker on a memory read path. When the first correctable (single-bit) or uncorrectable (multi-bit) event arrives while the log is empty, it stores two things: the high-order bits of the failing address and the syndrome. It also sets one of two sticky status flags to show which kind of event was recorded. Later events leave the log untouched until software has cleared the flag. Everything is visible in one register that can be read and written. Two enable bits in that register gate a non-maskable interrupt request for correctable events and a system-error request for uncorrectable ones.

The block also produces a scrub request. For every correctable read it issues a one-cycle pulse carrying that read's upper address bits, so that a write-back engine can rewrite the corrected word. Software can turn this off with a disable bit in the same register. An uncorrectable event never produces a scrub request.

Top module: `ecc_err_log`

## Requirements
- R1: After reset the register reads all zero and `nmi_req`, `serr_req` and `scrub_req` are low.
- R2: With both flags clear, a single-bit event (`sbe_evt`=1, `mbe_evt`=0) sets bit 0 on the next cycle. In the same cycle it loads bits 30:12 with `evt_addr[31:13]` and bits 11:4 with `evt_syn`, and bit 1 stays 0.
- R3: With both flags clear, a multi-bit event sets bit 1 on the next cycle and captures the address and syndrome in the same way as R2. Bit 0 stays 0.
- R4: If both event inputs are high in the same cycle while the log is empty, the multi-bit event is recorded: bits 1:0 read 2'b10.
- R5: While bit 0 or bit 1 is set, no event changes bits 30:4 or bits 1:0. Only a clearing write changes them.
- R6: Writing 1 to bit 0 or bit 1 clears that flag, and writing 0 to them leaves them unchanged. After both are clear, the next event is captured.
- R7: Writes have no effect on bits 30:4.
- R8: Bit 2 is the NMI enable. `nmi_req` is high exactly while bit 0 and bit 2 are both set, and it drops in the cycle after bit 0 is cleared.
- R9: Bit 3 is the SERR enable. `serr_req` is high exactly while bit 1 and bit 3 are both set.
- R10: Bit 31 is the scrub disable. A single-bit event without a multi-bit event in the same cycle, seen while bit 31 is 0, gives a `scrub_req` pulse of exactly one cycle in the next cycle, with `scrub_addr` = `evt_addr[31:13]` of that event. This happens even while the log is held. Bit 31 = 1 suppresses the pulse.
- R11: Bits 31, 3 and 2 read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sbe_evt | input | 1 | Corrected single-bit error on this read |
| mbe_evt | input | 1 | Uncorrectable multi-bit error on this read |
| evt_addr | input | ADDR_W | Address of the read |
| evt_syn | input | SYN_W | Syndrome of the read |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read value |
| nmi_req | output | 1 | Level NMI request for a logged single-bit error |
| serr_req | output | 1 | Level system-error request for a logged multi-bit error |
| scrub_req | output | 1 | One-cycle scrub request |
| scrub_addr | output | TAG_W | Upper address bits for the scrub |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 19-bit address tag and an 8-bit syndrome. With these values the register is exactly 32 bits, and the field positions named in the requirements apply. A queue holds the expected scrub addresses; every pulse must match the next entry, and the queue must be empty at the end. This catches extra, missing or stretched pulses while the log is held and while scrubbing is disabled. The direct register checks cover capture priority, the hold behaviour, write-one-to-clear with both 0 and 1 written, and interrupt gating in both directions.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  typedef enum logic [1:0] {EV_NONE = 2'd0, EV_SBE = 2'd1, EV_MBE = 2'd2} ev_kind_t;

  function automatic ev_kind_t classify(input logic sbe, input logic mbe);
    if (mbe)      return EV_MBE;
    else if (sbe) return EV_SBE;
    else          return EV_NONE;
  endfunction
endpackage

// File: rtl/ecc_log_capture.sv
module ecc_log_capture
  import ecc_log_pkg::*;
#(
  parameter int TAG_W = 19,
  parameter int SYN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sbe_evt,
  input  logic             mbe_evt,
  input  logic [TAG_W-1:0] evt_tag,
  input  logic [SYN_W-1:0] evt_syn,
  input  logic             clr_sbe,
  input  logic             clr_mbe,
  output logic             sbe_flag,
  output logic             mbe_flag,
  output logic [TAG_W-1:0] log_tag,
  output logic [SYN_W-1:0] log_syn
);
  ev_kind_t   kind;
  logic       armed;
  logic       capture;
  logic       sbe_d, mbe_d;

  always_comb begin
    kind    = classify(sbe_evt, mbe_evt);
    armed   = !sbe_flag && !mbe_flag;
    capture = armed && (kind != EV_NONE);
    if (capture) begin
      sbe_d = (kind == EV_SBE);
      mbe_d = (kind == EV_MBE);
    end else begin
      sbe_d = sbe_flag && !clr_sbe;
      mbe_d = mbe_flag && !clr_mbe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbe_flag <= 1'b0;
      mbe_flag <= 1'b0;
    end else begin
      sbe_flag <= sbe_d;
      mbe_flag <= mbe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_tag <= '0;
      log_syn <= '0;
    end else if (capture) begin
      log_tag <= evt_tag;
      log_syn <= evt_syn;
    end
  end
endmodule

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_scrub_dis,
  input  logic wr_serr_en,
  input  logic wr_nmi_en,
  output logic scrub_dis,
  output logic serr_en,
  output logic nmi_en
);
  logic scrub_dis_d, serr_en_d, nmi_en_d;

  always_comb begin
    scrub_dis_d = scrub_dis;
    serr_en_d   = serr_en;
    nmi_en_d    = nmi_en;
    if (wr_en) begin
      scrub_dis_d = wr_scrub_dis;
      serr_en_d   = wr_serr_en;
      nmi_en_d    = wr_nmi_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scrub_dis <= 1'b0;
      serr_en   <= 1'b0;
      nmi_en    <= 1'b0;
    end else begin
      scrub_dis <= scrub_dis_d;
      serr_en   <= serr_en_d;
      nmi_en    <= nmi_en_d;
    end
  end
endmodule

// File: rtl/ecc_log_scrub.sv
module ecc_log_scrub
  import ecc_log_pkg::*;
#(
  parameter int TAG_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sbe_evt,
  input  logic             mbe_evt,
  input  logic             scrub_dis,
  input  logic [TAG_W-1:0] evt_tag,
  output logic             scrub_req,
  output logic [TAG_W-1:0] scrub_addr
);
  logic fire;

  always_comb fire = (classify(sbe_evt, mbe_evt) == EV_SBE) && !scrub_dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scrub_req <= 1'b0;
    else        scrub_req <= fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    scrub_addr <= '0;
    else if (fire) scrub_addr <= evt_tag;
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 19,
  parameter int SYN_W  = 8,
  localparam int REG_W = 4 + SYN_W + TAG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sbe_evt,
  input  logic              mbe_evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [SYN_W-1:0]  evt_syn,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              nmi_req,
  output logic              serr_req,
  output logic              scrub_req,
  output logic [TAG_W-1:0]  scrub_addr
);
  localparam int SBE_BIT  = 0;
  localparam int MBE_BIT  = 1;
  localparam int NMI_BIT  = 2;
  localparam int SERR_BIT = 3;
  localparam int SYN_LSB  = 4;
  localparam int TAG_LSB  = SYN_LSB + SYN_W;
  localparam int DIS_BIT  = TAG_LSB + TAG_W;

  logic [TAG_W-1:0] evt_tag;
  logic             sbe_flag, mbe_flag;
  logic [TAG_W-1:0] log_tag;
  logic [SYN_W-1:0] log_syn;
  logic             scrub_dis, serr_en, nmi_en;
  logic             clr_sbe, clr_mbe;
  logic             unused_bits;

  assign evt_tag     = evt_addr[ADDR_W-1 -: TAG_W];
  assign clr_sbe     = reg_wr_en && reg_wdata[SBE_BIT];
  assign clr_mbe     = reg_wr_en && reg_wdata[MBE_BIT];
  assign unused_bits = ^{reg_wdata[DIS_BIT-1:SYN_LSB], evt_addr[ADDR_W-TAG_W-1:0]};

  ecc_log_capture #(.TAG_W(TAG_W), .SYN_W(SYN_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .sbe_evt(sbe_evt), .mbe_evt(mbe_evt),
    .evt_tag(evt_tag), .evt_syn(evt_syn), .clr_sbe(clr_sbe), .clr_mbe(clr_mbe),
    .sbe_flag(sbe_flag), .mbe_flag(mbe_flag), .log_tag(log_tag), .log_syn(log_syn)
  );

  ecc_log_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en),
    .wr_scrub_dis(reg_wdata[DIS_BIT]), .wr_serr_en(reg_wdata[SERR_BIT]),
    .wr_nmi_en(reg_wdata[NMI_BIT]),
    .scrub_dis(scrub_dis), .serr_en(serr_en), .nmi_en(nmi_en)
  );

  ecc_log_scrub #(.TAG_W(TAG_W)) u_scrub (
    .clk(clk), .rst_n(rst_n), .sbe_evt(sbe_evt), .mbe_evt(mbe_evt),
    .scrub_dis(scrub_dis), .evt_tag(evt_tag),
    .scrub_req(scrub_req), .scrub_addr(scrub_addr)
  );

  always_comb begin
    reg_rdata                         = '0;
    reg_rdata[DIS_BIT]                = scrub_dis;
    reg_rdata[DIS_BIT-1:TAG_LSB]      = log_tag;
    reg_rdata[TAG_LSB-1:SYN_LSB]      = log_syn;
    reg_rdata[SERR_BIT]               = serr_en;
    reg_rdata[NMI_BIT]                = nmi_en;
    reg_rdata[MBE_BIT]                = mbe_flag;
    reg_rdata[SBE_BIT]                = sbe_flag;
    nmi_req                           = sbe_flag && nmi_en;
    serr_req                          = mbe_flag && serr_en;
  end
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int TAG_W = 19,
  parameter int SYN_W = 8,
  localparam int REG_W = 4 + SYN_W + TAG_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sbe_evt,
  input logic             mbe_evt,
  input logic             reg_wr_en,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             nmi_req,
  input logic             serr_req,
  input logic             scrub_req
);
  localparam int DIS_BIT = REG_W - 1;

  logic flag_any, clr_hit;
  assign flag_any = reg_rdata[1] || reg_rdata[0];
  assign clr_hit  = reg_wr_en && ((reg_wdata[1] && reg_rdata[1]) || (reg_wdata[0] && reg_rdata[0]));

  p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_rdata[1:0]));

  p_mbe_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_any && sbe_evt && mbe_evt) |=> (reg_rdata[1:0] == 2'b10));

  p_log_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_any && !clr_hit) |=> ($stable(reg_rdata[DIS_BIT-1:4]) && $stable(reg_rdata[1:0])));

  p_nmi_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req == (reg_rdata[0] && reg_rdata[2]));

  p_serr_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    serr_req == (reg_rdata[1] && reg_rdata[3]));

  p_scrub_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    scrub_req |-> $past(sbe_evt && !mbe_evt && !reg_rdata[DIS_BIT]));

  p_scrub_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[DIS_BIT] && !reg_wr_en) |=> !scrub_req);
endmodule

bind ecc_err_log ecc_err_log_chk #(.TAG_W(TAG_W), .SYN_W(SYN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sbe_evt(sbe_evt), .mbe_evt(mbe_evt),
  .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .nmi_req(nmi_req), .serr_req(serr_req), .scrub_req(scrub_req)
);

// File: tb/test_ecc_err_log.sv
module test_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sbe_evt = 1'b0, mbe_evt = 1'b0;
  logic [31:0] evt_addr = '0;
  logic [7:0]  evt_syn = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        nmi_req, serr_req, scrub_req;
  logic [18:0] scrub_addr;

  int checks = 0;
  int errors = 0;
  logic [18:0] exp_q[$];

  always #4 clk = ~clk;

  ecc_err_log i_ecc_err_log (
    .clk(clk), .rst_n(rst_n), .sbe_evt(sbe_evt), .mbe_evt(mbe_evt),
    .evt_addr(evt_addr), .evt_syn(evt_syn), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_req(nmi_req),
    .serr_req(serr_req), .scrub_req(scrub_req), .scrub_addr(scrub_addr)
  );

  function automatic logic [31:0] mk(input logic dis, input logic [31:0] a, input logic [7:0] s,
                                     input logic serr, input logic nmi, input logic mbe, input logic sbe);
    return {dis, a[31:13], s, serr, nmi, mbe, sbe};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one event cycle; pushes expected scrub address
  task automatic evt(input logic s, input logic m, input logic [31:0] a, input logic [7:0] y,
                     input logic dis);
    @(negedge clk);
    sbe_evt = s; mbe_evt = m; evt_addr = a; evt_syn = y;
    if (s && !m && !dis) exp_q.push_back(a[31:13]);
    @(negedge clk);
    sbe_evt = 1'b0; mbe_evt = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  // monitor: every scrub pulse must match the next queued address
  always @(negedge clk) begin
    if (rst_n && scrub_req) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected scrub pulse actual addr %h expected none", scrub_addr);
      end else begin
        logic [18:0] e;
        e = exp_q.pop_front();
        if (scrub_addr !== e) begin
          errors++;
          $display("FAIL R10 scrub addr actual %h expected %h", scrub_addr, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reg", reg_rdata, 32'h0);
    chk("R1 irq/scrub", {29'd0, nmi_req, serr_req, scrub_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(32'h8000_000C);
    chk("R11 ctrl readback", reg_rdata, 32'h8000_000C);
    wr(32'h0);
    chk("R11 ctrl cleared", reg_rdata, 32'h0);

    evt(1'b1, 1'b0, 32'hDEAD_B000, 8'h5A, 1'b0);
    chk("R2 sbe capture", reg_rdata, mk(0, 32'hDEAD_B000, 8'h5A, 0, 0, 0, 1));
    chk("R8 nmi gated off", {31'd0, nmi_req}, 32'h0);

    evt(1'b0, 1'b1, 32'h1234_5678, 8'hC3, 1'b0);
    chk("R5 held on mbe", reg_rdata, mk(0, 32'hDEAD_B000, 8'h5A, 0, 0, 0, 1));
    evt(1'b1, 1'b0, 32'h0F0F_E000, 8'h11, 1'b0);
    chk("R5 held on sbe", reg_rdata, mk(0, 32'hDEAD_B000, 8'h5A, 0, 0, 0, 1));

    wr(32'h0);
    chk("R6 write zero keeps flag", reg_rdata, mk(0, 32'hDEAD_B000, 8'h5A, 0, 0, 0, 1));
    wr(32'h7FFF_FFF0);
    chk("R7 ro fields ignore write", reg_rdata, mk(0, 32'hDEAD_B000, 8'h5A, 0, 0, 0, 1));

    wr(32'h4);
    chk("R8 nmi asserted", {31'd0, nmi_req}, 32'h1);
    chk("R9 serr low on sbe", {31'd0, serr_req}, 32'h0);
    wr(32'h5);
    chk("R6 sbe cleared", reg_rdata[1:0], 32'h0);
    chk("R8 nmi dropped", {31'd0, nmi_req}, 32'h0);

    evt(1'b0, 1'b1, 32'hA5A5_2000, 8'h81, 1'b0);
    chk("R3 mbe capture", reg_rdata, mk(0, 32'hA5A5_2000, 8'h81, 0, 1, 1, 0));
    chk("R9 serr gated off", {31'd0, serr_req}, 32'h0);
    chk("R8 nmi low on mbe", {31'd0, nmi_req}, 32'h0);
    wr(32'h8);
    chk("R9 serr asserted", {31'd0, serr_req}, 32'h1);
    wr(32'hA);
    chk("R9 serr dropped", {31'd0, serr_req}, 32'h0);
    chk("R6 mbe cleared", reg_rdata[1:0], 32'h0);

    evt(1'b1, 1'b1, 32'h7777_6000, 8'h3C, 1'b0);
    chk("R4 mbe wins", reg_rdata, mk(0, 32'h7777_6000, 8'h3C, 1, 0, 1, 0));
    wr(32'h2);

    wr(32'h8000_0000);
    evt(1'b1, 1'b0, 32'h4242_8000, 8'h99, 1'b1);
    chk("R10 disabled still logs", reg_rdata, mk(1, 32'h4242_8000, 8'h99, 0, 0, 0, 1));
    wr(32'h0000_0001);
    evt(1'b1, 1'b0, 32'hFFFF_E000, 8'hFF, 1'b0);
    chk("R6 rearmed capture", reg_rdata, mk(0, 32'hFFFF_E000, 8'hFF, 0, 0, 0, 1));

    repeat (3) @(negedge clk);
    chk("R10 all scrubs seen", exp_q.size(), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule